// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Controller

This block keeps the status byte of a serial EEPROM and decides whether each write request may go ahead. An SPI front end hands it decoded one-cycle instruction strobes: set the write-enable latch, clear it, snapshot the status byte, write the status byte (with a data byte), and write memory (with a target address). The block also watches the active-low write-protect pin, a supply-drop indication and a soft power-on pulse.

Every accepted write starts an internal write cycle of `WR_CYCLES` clocks. While the cycle runs, the write-in-progress flag is high and every strobe except the status snapshot is dropped. The nonvolatile bits are ordinary registers. A soft power-on or a supply drop leaves them untouched, and only the hard reset clears them. Grant and reject are one-cycle pulses that appear in the cycle after the request strobe.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0: lock bit, three bits fixed at 0, block-protect high, block-protect low, write-enable latch, write-in-progress. After hard reset it is 0x00.
- R2: When the lock bit is 1 and `wp_n` is low, a status write is rejected and bits 7..2 keep their value.
- R3: When `wp_n` is high, a status write is granted even with the lock bit set, and it can clear the lock and block-protect bits.
- R4: A granted status write stores only data bits 7, 3 and 2. The other data bits have no effect on the status byte.
- R5: Only the set-enable strobe sets the write-enable latch. With the latch at 0, status writes and memory writes get a `reject` pulse and no `grant`. Grant and reject appear in the cycle after the strobe, and never together.
- R6: The write-enable latch clears when the clear-enable strobe arrives and when a write cycle completes.
- R7: After a grant, write-in-progress reads 1 for exactly `WR_CYCLES` cycles and then returns to 0.
- R8: While write-in-progress is 1, every strobe other than the status snapshot is ignored. This holds in the final busy cycle too: there is no grant or reject, and the status byte does not change.
- R9: The status snapshot strobe copies the current status byte to `status_snap` in the next cycle, even during a write cycle.
- R10: The block-protect code (bits 3:2) protects addresses as follows: 01 protects the top quarter, 10 the top half, 11 every address, and 00 none. A memory write to a protected address is rejected and leaves the write-enable latch set.
- R11: `soft_por` or `vdd_low` clears the write-enable latch and ends any write cycle, and keeps bits 7..2.
- R12: When several strobes arrive in one cycle, the priority is clear-enable, then set-enable, then status write, then memory write.
- R13: Hard reset returns the lock and block-protect bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_por | input | 1 | Soft power-on pulse |
| vdd_low | input | 1 | Supply-drop indication |
| wp_n | input | 1 | Active-low write-protect pin |
| cmd_wr_en | input | 1 | Set-enable strobe |
| cmd_wr_dis | input | 1 | Clear-enable strobe |
| cmd_stat_rd | input | 1 | Status snapshot strobe |
| cmd_stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Data byte for a status write |
| cmd_mem_wr | input | 1 | Memory write strobe |
| mem_addr | input | ADDR_W | Target address of a memory write |
| status | output | 8 | Live status byte |
| status_snap | output | 8 | Status byte captured by the last snapshot strobe |
| grant | output | 1 | Write request accepted (one-cycle pulse) |
| reject | output | 1 | Write request refused (one-cycle pulse) |
| busy | output | 1 | Write cycle in progress |

## Verification
Two events can land on the same clock edge: the last count of the write-cycle timer, which clears the enable latch, and a new set-enable strobe. The bench issues the set-enable strobe on exactly that final busy edge. It then expects the latch to read 0, because the strobe was ignored, and it expects a repeat of the strobe one cycle later to set the latch. The bench also drives competing strobes in a single cycle and judges which one won from the resulting status byte.

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl #(
  parameter int ADDR_W    = 14,
  parameter int WR_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_por,
  input  logic              vdd_low,
  input  logic              wp_n,
  input  logic              cmd_wr_en,
  input  logic              cmd_wr_dis,
  input  logic              cmd_stat_rd,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        status,
  output logic [7:0]        status_snap,
  output logic              grant,
  output logic              reject,
  output logic              busy
);
  localparam int              TW      = $clog2(WR_CYCLES + 1);
  localparam logic [TW-1:0]   LOAD    = TW'(WR_CYCLES);
  localparam logic [TW-1:0]   ONE     = TW'(1);
  localparam logic [7:0]      NV_MASK = 8'h8C;
  localparam logic [ADDR_W:0] SPAN    = {1'b1, {ADDR_W{1'b0}}};

  logic [7:0]        nv_q;
  logic              wel_q;
  logic [TW-1:0]     tmr_q;
  logic [ADDR_W:0]   floor_addr;
  logic              hw_lock, blk_hit, power_drop;

  assign busy       = tmr_q != '0;
  assign status     = nv_q | {6'b0, wel_q, busy};
  assign hw_lock    = nv_q[7] & ~wp_n;
  assign power_drop = soft_por | vdd_low;
  assign blk_hit    = {1'b0, mem_addr} >= floor_addr;

  always_comb begin
    case (nv_q[3:2])
      2'b00:   floor_addr = SPAN;
      2'b01:   floor_addr = SPAN - (SPAN >> 2);
      2'b10:   floor_addr = SPAN >> 1;
      default: floor_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q        <= '0;
      wel_q       <= 1'b0;
      tmr_q       <= '0;
      grant       <= 1'b0;
      reject      <= 1'b0;
      status_snap <= '0;
    end else begin
      grant  <= 1'b0;
      reject <= 1'b0;
      if (cmd_stat_rd) status_snap <= status;
      if (power_drop) begin
        wel_q <= 1'b0;
        tmr_q <= '0;
      end else if (busy) begin
        tmr_q <= tmr_q - ONE;
        if (tmr_q == ONE) wel_q <= 1'b0;
      end else if (cmd_wr_dis) begin
        wel_q <= 1'b0;
      end else if (cmd_wr_en) begin
        wel_q <= 1'b1;
      end else if (cmd_stat_wr) begin
        if (wel_q && !hw_lock) begin
          nv_q  <= stat_wdata & NV_MASK;
          tmr_q <= LOAD;
          grant <= 1'b1;
        end else begin
          reject <= 1'b1;
        end
      end else if (cmd_mem_wr) begin
        if (wel_q && !blk_hit) begin
          tmr_q <= LOAD;
          grant <= 1'b1;
        end else begin
          reject <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl_chk.sv
module eeprom_wp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_por,
  input logic       vdd_low,
  input logic       wp_n,
  input logic       cmd_wr_en,
  input logic       cmd_wr_dis,
  input logic       cmd_stat_wr,
  input logic [7:0] status,
  input logic       grant,
  input logic       reject,
  input logic       busy
);
  assert_fixed_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  assert_hw_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stat_wr && !cmd_wr_en && !cmd_wr_dis && status[7] && !wp_n && !busy && !soft_por && !vdd_low)
    |=> (!grant && $stable(status[7:2])));

  assert_no_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  assert_latch_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cmd_wr_en && !cmd_wr_dis));

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);

  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy);

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!grant && !reject));

  assert_power_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_por || vdd_low) |=> (status[1:0] == 2'b00 && $stable(status[7:2])));
endmodule

bind eeprom_wp_ctrl eeprom_wp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_por(soft_por), .vdd_low(vdd_low), .wp_n(wp_n),
  .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis), .cmd_stat_wr(cmd_stat_wr),
  .status(status), .grant(grant), .reject(reject), .busy(busy)
);

// File: tb/eeprom_wp_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_wp_ctrl_test;
  localparam int AW = 8;
  localparam int WR = 6;

  typedef enum int {C_IDLE, C_EN, C_DIS, C_RD, C_SW, C_MW, C_POR, C_VDD, C_EN_DIS, C_SW_MW} cmd_t;
  typedef struct {
    logic g; logic r; logic [7:0] st; logic chk_rd; logic [7:0] rd; string tag;
  } item_t;

  logic clk = 0, rst_n = 0, soft_por = 0, vdd_low = 0, wp_n = 1;
  logic cmd_wr_en = 0, cmd_wr_dis = 0, cmd_stat_rd = 0, cmd_stat_wr = 0, cmd_mem_wr = 0;
  logic [7:0] stat_wdata = 0;
  logic [AW-1:0] mem_addr = 0;
  logic [7:0] status, status_snap;
  logic grant, reject, busy;

  int errors = 0, checks = 0;
  bit armed = 0;
  item_t q[$];

  always #2 clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(AW), .WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .soft_por(soft_por), .vdd_low(vdd_low), .wp_n(wp_n),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis), .cmd_stat_rd(cmd_stat_rd),
    .cmd_stat_wr(cmd_stat_wr), .stat_wdata(stat_wdata), .cmd_mem_wr(cmd_mem_wr),
    .mem_addr(mem_addr), .status(status), .status_snap(status_snap),
    .grant(grant), .reject(reject), .busy(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic op(input cmd_t c, input logic [7:0] d, input logic [7:0] a,
                    input logic eg, input logic er, input logic [7:0] es, input string tag);
    item_t it;
    @(negedge clk);
    cmd_wr_en   = (c == C_EN) || (c == C_EN_DIS);
    cmd_wr_dis  = (c == C_DIS) || (c == C_EN_DIS);
    cmd_stat_rd = (c == C_RD);
    cmd_stat_wr = (c == C_SW) || (c == C_SW_MW);
    cmd_mem_wr  = (c == C_MW) || (c == C_SW_MW);
    soft_por    = (c == C_POR);
    vdd_low     = (c == C_VDD);
    stat_wdata  = d;
    mem_addr    = a;
    it.g = eg; it.r = er; it.st = es; it.chk_rd = (c == C_RD); it.rd = es; it.tag = tag;
    q.push_back(it);
    armed = 1;
  endtask

  task automatic idle(input logic [7:0] es, input string tag);
    op(C_IDLE, 8'h00, 8'h00, 1'b0, 1'b0, es, tag);
  endtask

  task automatic drain(input logic [7:0] busy_st, input logic [7:0] done_st, input string tag);
    for (int k = 0; k < WR - 1; k++) idle(busy_st, tag);
    idle(done_st, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (armed) begin
      item_t it;
      armed = 0;
      it = q.pop_front();
      check({it.tag, " grant"}, {7'b0, grant}, {7'b0, it.g});
      check({it.tag, " reject"}, {7'b0, reject}, {7'b0, it.r});
      check({it.tag, " status"}, status, it.st);
      if (it.chk_rd) check({it.tag, " snapshot"}, status_snap, it.rd);
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    rst_n = 1;
    op(C_SW, 8'hFF, 8'h00, 0, 1, 8'h00, "R5 status write without latch");
    op(C_MW, 8'h00, 8'h00, 0, 1, 8'h00, "R5 memory write without latch");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h02, "R5 set latch");
    op(C_SW, 8'hFF, 8'h00, 1, 0, 8'h8F, "R4 masked status write");
    op(C_DIS, 8'h00, 8'h00, 0, 0, 8'h8F, "R8 clear ignored while busy");
    op(C_RD, 8'h00, 8'h00, 0, 0, 8'h8F, "R9 snapshot while busy");
    for (int k = 0; k < WR - 3; k++) idle(8'h8F, "R7 still busy");
    idle(8'h8C, "R6 latch cleared at completion");

    wp_n = 0;
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h8E, "R5 set latch");
    op(C_SW, 8'h00, 8'h00, 0, 1, 8'h8E, "R2 hardware lock rejects");
    op(C_MW, 8'h00, 8'h00, 0, 1, 8'h8E, "R10 whole array protected");
    wp_n = 1;
    op(C_SW, 8'h00, 8'h00, 1, 0, 8'h03, "R3 unlocked status write");
    drain(8'h03, 8'h00, "R7 cycle length");

    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h02, "R5 set latch");
    op(C_SW, 8'h04, 8'h00, 1, 0, 8'h07, "R4 quarter code");
    drain(8'h07, 8'h04, "R6 completion");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h06, "R5 set latch");
    op(C_MW, 8'h00, 8'hC0, 0, 1, 8'h06, "R10 top quarter rejected");
    op(C_MW, 8'h00, 8'hBF, 1, 0, 8'h07, "R10 below quarter granted");
    drain(8'h07, 8'h04, "R6 memory write completion");

    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h06, "R5 set latch");
    op(C_SW, 8'h08, 8'h00, 1, 0, 8'h0B, "R4 half code");
    drain(8'h0B, 8'h08, "R7 cycle length");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R5 set latch");
    op(C_MW, 8'h00, 8'h80, 0, 1, 8'h0A, "R10 top half rejected");
    op(C_MW, 8'h00, 8'h7F, 1, 0, 8'h0B, "R10 lower half granted");
    drain(8'h0B, 8'h08, "R7 cycle length");

    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R5 set latch");
    op(C_MW, 8'h00, 8'h00, 1, 0, 8'h0B, "R10 low address granted");
    op(C_POR, 8'h00, 8'h00, 0, 0, 8'h08, "R11 soft power-on");
    idle(8'h08, "R11 cycle stays ended");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R5 set latch");
    op(C_VDD, 8'h00, 8'h00, 0, 0, 8'h08, "R11 supply drop");

    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R5 set latch");
    op(C_MW, 8'h00, 8'h00, 1, 0, 8'h0B, "R10 low address granted");
    for (int k = 0; k < WR - 1; k++) idle(8'h0B, "R7 still busy");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h08, "R8 set on final busy edge ignored");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R8 set after completion");

    op(C_EN_DIS, 8'h00, 8'h00, 0, 0, 8'h08, "R12 clear beats set");
    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h0A, "R5 set latch");
    op(C_SW_MW, 8'h00, 8'h00, 1, 0, 8'h03, "R12 status write beats memory write");
    drain(8'h03, 8'h00, "R7 cycle length");

    op(C_EN, 8'h00, 8'h00, 0, 0, 8'h02, "R5 set latch");
    op(C_SW, 8'h8C, 8'h00, 1, 0, 8'h8F, "R4 full store");
    drain(8'h8F, 8'h8C, "R6 completion");
    idle(8'h8C, "R13 before reset");
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R13 hard reset clears nonvolatile bits", status, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule